// File: doc/BRIEF.md
# Integer Future File

This block keeps the speculative view of the integer register state in an out-of-order core. Every entry holds either the newest known value of its register or, while that value is still being computed, the reorder-buffer tag of the youngest in-flight instruction that writes it. Each cycle up to three instructions issue in program order, with lane 0 the oldest. Each one reads two source operands and claims one destination entry. The state covers the sixteen architectural registers and eight scratch-pad registers used by microcode, 24 entries in all.

Execution units broadcast finished results with their tag and destination. A result is kept only if it comes from the instruction that the entry still names as its youngest producer, so results from overwritten producers are discarded without any extra bookkeeping. Alongside the speculative copy, the block holds the committed value of each register, which is written by retirement.

On a mispredict or exception the whole committed copy is loaded into the speculative copy in one cycle. After that cycle every entry is ready again, with no free list or checkpoint to restore.

Top module: `future_regfile`

## Requirements
- R1: After reset every entry reads back ready with value 0, and the committed copy holds 0.
- R2: A source lookup returns ready=1 and the stored value when the entry is ready. Otherwise it returns ready=0 and the stored producer tag. Lane l uses bits [l*W +: W] of every packed lane field.
- R3: An issue into lane l with `flush` low makes its destination entry not ready and records that lane's tag, starting the next cycle.
- R4: A completion updates a not-ready entry, which then becomes ready with the result, only when its tag equals the entry's stored tag. A completion with any other tag leaves the entry unchanged.
- R5: A completion that would update an entry in the current cycle is bypassed combinationally to any source lookup of that entry in the same cycle.
- R6: When an instruction's destination equals one of its own sources, that source sees the entry as it was before this issue.
- R7: A source in lane l that names the destination of an older lane (index below l) issuing in the same cycle returns ready=0 with the tag of the youngest such older lane. When several lanes write one destination in a cycle, the highest lane's tag is the one recorded.
- R8: Retirement writes the committed copy of the destination register. When several retire lanes name one register in a cycle, the highest lane wins. The committed copy becomes visible only through a flush.
- R9: With `flush` high, the next cycle shows every entry ready, holding the committed values including this cycle's retirements. Issues and completions presented in the flush cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Recover speculative state from committed state |
| iss_vld | input | LANES | Issue valid per lane, lane 0 oldest |
| iss_srca | input | LANES*RW | First source register per lane |
| iss_srcb | input | LANES*RW | Second source register per lane |
| iss_dst | input | LANES*RW | Destination register per lane |
| iss_tag | input | LANES*TW | Reorder-buffer tag of the issuing instruction |
| a_rdy | output | LANES | First source value is available |
| a_val | output | LANES*DW | First source value |
| a_tag | output | LANES*TW | First source producer tag, meaningful when not ready |
| b_rdy | output | LANES | Second source value is available |
| b_val | output | LANES*DW | Second source value |
| b_tag | output | LANES*TW | Second source producer tag, meaningful when not ready |
| cmp_vld | input | LANES | Completion valid per result bus |
| cmp_dst | input | LANES*RW | Destination register of the completing instruction |
| cmp_tag | input | LANES*TW | Tag of the completing instruction |
| cmp_val | input | LANES*DW | Result value |
| ret_vld | input | LANES | Retire valid per lane |
| ret_dst | input | LANES*RW | Retiring destination register |
| ret_val | input | LANES*DW | Retiring value |

## Verification
A wrong tag or ready bit in an entry shows up on the first source lookup of that register, one cycle after the update that produced it. It appears as the wrong ready flag, or as a tag that no later completion matches, so the entry would stay not ready for good. A bad committed value stays hidden until the next flush and then appears on every lookup of that register in the following cycle. For this reason the stimulus flushes often and reads back heavily reused registers each cycle against a bench model.

// File: rtl/future_regfile.sv
module future_regfile #(
  parameter int DW    = 32,
  parameter int TW    = 7,
  parameter int NARCH = 16,
  parameter int NSCR  = 8,
  parameter int LANES = 3,
  localparam int NREG = NARCH + NSCR,
  localparam int RW   = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [LANES-1:0]    iss_vld,
  input  logic [LANES*RW-1:0] iss_srca,
  input  logic [LANES*RW-1:0] iss_srcb,
  input  logic [LANES*RW-1:0] iss_dst,
  input  logic [LANES*TW-1:0] iss_tag,
  output logic [LANES-1:0]    a_rdy,
  output logic [LANES*DW-1:0] a_val,
  output logic [LANES*TW-1:0] a_tag,
  output logic [LANES-1:0]    b_rdy,
  output logic [LANES*DW-1:0] b_val,
  output logic [LANES*TW-1:0] b_tag,
  input  logic [LANES-1:0]    cmp_vld,
  input  logic [LANES*RW-1:0] cmp_dst,
  input  logic [LANES*TW-1:0] cmp_tag,
  input  logic [LANES*DW-1:0] cmp_val,
  input  logic [LANES-1:0]    ret_vld,
  input  logic [LANES*RW-1:0] ret_dst,
  input  logic [LANES*DW-1:0] ret_val
);

  logic [NREG-1:0][DW-1:0] fut_val, com_val, com_nxt;
  logic [NREG-1:0][TW-1:0] fut_tag;
  logic [NREG-1:0]         fut_vld;

  typedef struct packed {
    logic          rdy;
    logic [DW-1:0] val;
    logic [TW-1:0] tag;
  } opnd_t;

  function automatic opnd_t look(input logic [RW-1:0] s, input int lane);
    opnd_t o;
    o.rdy = fut_vld[s];
    o.val = fut_val[s];
    o.tag = fut_tag[s];
    for (int k = 0; k < LANES; k++)
      if (cmp_vld[k] && !fut_vld[s] && cmp_dst[k*RW +: RW] == s &&
          cmp_tag[k*TW +: TW] == fut_tag[s]) begin
        o.rdy = 1'b1;
        o.val = cmp_val[k*DW +: DW];
      end
    for (int j = 0; j < LANES; j++)
      if (j < lane && iss_vld[j] && iss_dst[j*RW +: RW] == s) begin
        o.rdy = 1'b0;
        o.tag = iss_tag[j*TW +: TW];
      end
    return o;
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    opnd_t oa, ob;
    assign oa = look(iss_srca[l*RW +: RW], l);
    assign ob = look(iss_srcb[l*RW +: RW], l);
    assign a_rdy[l]         = oa.rdy;
    assign a_val[l*DW +: DW] = oa.val;
    assign a_tag[l*TW +: TW] = oa.tag;
    assign b_rdy[l]         = ob.rdy;
    assign b_val[l*DW +: DW] = ob.val;
    assign b_tag[l*TW +: TW] = ob.tag;
  end

  always_comb begin
    com_nxt = com_val;
    for (int k = 0; k < LANES; k++)
      if (ret_vld[k]) com_nxt[ret_dst[k*RW +: RW]] = ret_val[k*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fut_vld <= '1;
      fut_val <= '0;
      fut_tag <= '0;
      com_val <= '0;
    end else begin
      com_val <= com_nxt;
      if (flush) begin
        fut_val <= com_nxt;
        fut_vld <= '1;
      end else begin
        for (int k = 0; k < LANES; k++)
          if (cmp_vld[k] && !fut_vld[cmp_dst[k*RW +: RW]] &&
              fut_tag[cmp_dst[k*RW +: RW]] == cmp_tag[k*TW +: TW]) begin
            fut_val[cmp_dst[k*RW +: RW]] <= cmp_val[k*DW +: DW];
            fut_vld[cmp_dst[k*RW +: RW]] <= 1'b1;
          end
        for (int l = 0; l < LANES; l++)
          if (iss_vld[l]) begin
            fut_vld[iss_dst[l*RW +: RW]] <= 1'b0;
            fut_tag[iss_dst[l*RW +: RW]] <= iss_tag[l*TW +: TW];
          end
      end
    end
  end

endmodule

// File: rtl/future_regfile_chk.sv
module future_regfile_chk #(
  parameter int DW = 32, parameter int TW = 7,
  parameter int NREG = 24, parameter int RW = 5, parameter int LANES = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    flush,
  input logic [LANES-1:0]        iss_vld,
  input logic [LANES*RW-1:0]     iss_dst,
  input logic [TW-1:0]           t_last,
  input logic [LANES-1:0]        cmp_vld,
  input logic [RW-1:0]           c0,
  input logic [TW-1:0]           ct0,
  input logic                    rv_last_vld,
  input logic [RW-1:0]           rd_last,
  input logic [DW-1:0]           rv_last,
  input logic [NREG-1:0]         fut_vld,
  input logic [NREG-1:0][TW-1:0] fut_tag,
  input logic [NREG-1:0][DW-1:0] fut_val,
  input logic [NREG-1:0][DW-1:0] com_val
);
  logic [RW-1:0] d_last;
  logic          iss_hit_c0;
  assign d_last = iss_dst[(LANES-1)*RW +: RW];
  always_comb begin
    iss_hit_c0 = 1'b0;
    for (int l = 0; l < LANES; l++)
      if (iss_vld[l] && iss_dst[l*RW +: RW] == c0) iss_hit_c0 = 1'b1;
  end

  // R9
  flush_all_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> &fut_vld);

  // R3
  issue_claims_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && iss_vld[LANES-1]) |=>
      (!fut_vld[$past(d_last)] && fut_tag[$past(d_last)] == $past(t_last)));

  // R4
  stale_result_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && cmp_vld == LANES'(1) && fut_tag[c0] != ct0 && !iss_hit_c0) |=>
      (fut_val[$past(c0)] == $past(fut_val[c0])));

  // R8
  retire_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rv_last_vld |=> (com_val[$past(rd_last)] == $past(rv_last)));
endmodule

bind future_regfile future_regfile_chk #(
  .DW(DW), .TW(TW), .NREG(NREG), .RW(RW), .LANES(LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .iss_vld(iss_vld), .iss_dst(iss_dst),
  .t_last(iss_tag[(LANES-1)*TW +: TW]),
  .cmp_vld(cmp_vld), .c0(cmp_dst[RW-1:0]), .ct0(cmp_tag[TW-1:0]),
  .rv_last_vld(ret_vld[LANES-1]),
  .rd_last(ret_dst[(LANES-1)*RW +: RW]),
  .rv_last(ret_val[(LANES-1)*DW +: DW]),
  .fut_vld(fut_vld), .fut_tag(fut_tag), .fut_val(fut_val), .com_val(com_val)
);

// File: tb/tb_future_regfile.sv
module tb_future_regfile;
  localparam int DW = 32, TW = 7, L = 3, NREG = 24, RW = 5;

  logic clk = 1'b0, rst_n = 1'b0, flush;
  logic [L-1:0] iss_vld, a_rdy, b_rdy, cmp_vld, ret_vld;
  logic [L*RW-1:0] iss_srca, iss_srcb, iss_dst, cmp_dst, ret_dst;
  logic [L*TW-1:0] iss_tag, a_tag, b_tag, cmp_tag;
  logic [L*DW-1:0] a_val, b_val, cmp_val, ret_val;

  future_regfile dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] mval[NREG], mcom[NREG];
  logic [TW-1:0] mtag[NREG];
  logic          mvld[NREG];

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in;
    flush = 0; iss_vld = '0; iss_srca = '0; iss_srcb = '0; iss_dst = '0; iss_tag = '0;
    cmp_vld = '0; cmp_dst = '0; cmp_tag = '0; cmp_val = '0;
    ret_vld = '0; ret_dst = '0; ret_val = '0;
  endtask

  task automatic put_src(int l, int a, int b);
    iss_srca[l*RW +: RW] = RW'(a); iss_srcb[l*RW +: RW] = RW'(b);
  endtask
  task automatic put_iss(int l, int d, int a, int b, int t);
    put_src(l, a, b); iss_vld[l] = 1'b1;
    iss_dst[l*RW +: RW] = RW'(d); iss_tag[l*TW +: TW] = TW'(t);
  endtask
  task automatic put_cmp(int k, int d, int t, logic [DW-1:0] v);
    cmp_vld[k] = 1'b1; cmp_dst[k*RW +: RW] = RW'(d);
    cmp_tag[k*TW +: TW] = TW'(t); cmp_val[k*DW +: DW] = v;
  endtask
  task automatic put_ret(int k, int d, logic [DW-1:0] v);
    ret_vld[k] = 1'b1; ret_dst[k*RW +: RW] = RW'(d); ret_val[k*DW +: DW] = v;
  endtask

  task automatic model_look(int s, int lane, output logic rdy, output logic [DW-1:0] val,
                            output logic [TW-1:0] tag, output string req);
    req = "R2"; rdy = mvld[s]; val = mval[s]; tag = mtag[s];
    if (iss_vld[lane] && int'(iss_dst[lane*RW +: RW]) == s) req = "R6";
    for (int k = 0; k < L; k++)
      if (cmp_vld[k] && !mvld[s] && int'(cmp_dst[k*RW +: RW]) == s && cmp_tag[k*TW +: TW] == mtag[s]) begin
        rdy = 1'b1; val = cmp_val[k*DW +: DW]; req = "R5";
      end
    for (int j = 0; j < lane; j++)
      if (iss_vld[j] && int'(iss_dst[j*RW +: RW]) == s) begin
        rdy = 1'b0; tag = iss_tag[j*TW +: TW]; req = "R7";
      end
  endtask

  task automatic model_check;
    logic r; logic [DW-1:0] v; logic [TW-1:0] t; string q;
    for (int l = 0; l < L; l++) begin
      model_look(int'(iss_srca[l*RW +: RW]), l, r, v, t, q);
      check(q, "a_rdy", 64'(a_rdy[l]), 64'(r));
      if (r) check(q, "a_val", 64'(a_val[l*DW +: DW]), 64'(v));
      else   check(q, "a_tag", 64'(a_tag[l*TW +: TW]), 64'(t));
      model_look(int'(iss_srcb[l*RW +: RW]), l, r, v, t, q);
      check(q, "b_rdy", 64'(b_rdy[l]), 64'(r));
      if (r) check(q, "b_val", 64'(b_val[l*DW +: DW]), 64'(v));
      else   check(q, "b_tag", 64'(b_tag[l*TW +: TW]), 64'(t));
    end
  endtask

  task automatic model_update;
    logic [DW-1:0] cn[NREG];
    cn = mcom;
    for (int k = 0; k < L; k++) if (ret_vld[k]) cn[ret_dst[k*RW +: RW]] = ret_val[k*DW +: DW];
    if (flush) begin
      for (int i = 0; i < NREG; i++) begin mval[i] = cn[i]; mvld[i] = 1'b1; end
    end else begin
      logic [DW-1:0] nv[NREG]; logic [TW-1:0] nt[NREG]; logic nd[NREG];
      nv = mval; nt = mtag; nd = mvld;
      for (int k = 0; k < L; k++) begin
        int d = int'(cmp_dst[k*RW +: RW]);
        if (cmp_vld[k] && !mvld[d] && mtag[d] == cmp_tag[k*TW +: TW]) begin
          nv[d] = cmp_val[k*DW +: DW]; nd[d] = 1'b1;
        end
      end
      for (int l = 0; l < L; l++)
        if (iss_vld[l]) begin
          nd[iss_dst[l*RW +: RW]] = 1'b0; nt[iss_dst[l*RW +: RW]] = iss_tag[l*TW +: TW];
        end
      mval = nv; mtag = nt; mvld = nd;
    end
    mcom = cn;
  endtask

  task automatic begin_cyc; @(negedge clk); clear_in; endtask
  task automatic settle; #1; model_check; endtask
  task automatic finish_cyc; @(posedge clk); model_update; endtask

  function automatic int pick;
    return ($urandom % 2) ? int'($urandom_range(0, 5)) : int'($urandom_range(0, NREG-1));
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_in;
    for (int i = 0; i < NREG; i++) begin mval[i] = '0; mcom[i] = '0; mtag[i] = '0; mvld[i] = 1'b1; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    begin_cyc; put_iss(0, 5, 5, 20, 11); put_iss(1, 7, 7, 5, 20); put_iss(2, 7, 7, 7, 21); settle;
    check("R6", "lane0 own-dst a_rdy", 64'(a_rdy[0]), 64'd1);
    check("R1", "lane0 b_val reset", 64'(b_val[DW-1:0]), 64'd0);
    check("R7", "lane2 a_tag", 64'(a_tag[2*TW +: TW]), 64'd20);
    check("R7", "lane1 b_tag", 64'(b_tag[TW +: TW]), 64'd11);
    finish_cyc;

    begin_cyc; put_src(0, 5, 7); put_cmp(0, 5, 12, 32'hDEAD); settle;
    check("R3", "reg5 tag", 64'(a_tag[TW-1:0]), 64'd11);
    check("R7", "reg7 youngest tag", 64'(b_tag[TW-1:0]), 64'd21);
    finish_cyc;

    begin_cyc; put_src(0, 5, 5); settle;
    check("R4", "stale result dropped", 64'(a_rdy[0]), 64'd0);
    finish_cyc;

    begin_cyc; put_src(1, 5, 5); put_cmp(1, 5, 11, 32'hAB); settle;
    check("R5", "bypass a_val", 64'(a_val[DW +: DW]), 64'hAB);
    finish_cyc;

    begin_cyc; put_src(0, 5, 7); settle;
    check("R4", "matching result kept", 64'(a_val[DW-1:0]), 64'hAB);
    finish_cyc;

    begin_cyc; flush = 1'b1; put_ret(0, 5, 32'h55); put_ret(2, 5, 32'h66);
    put_iss(0, 9, 1, 1, 3); put_cmp(0, 7, 21, 32'h77); settle; finish_cyc;

    begin_cyc; put_src(0, 5, 7); put_src(1, 9, 0); settle;
    check("R8", "committed highest lane", 64'(a_val[DW-1:0]), 64'h66);
    check("R9", "completion ignored at flush", 64'(b_val[DW-1:0]), 64'd0);
    check("R9", "issue ignored at flush", 64'(a_rdy[1]), 64'd1);
    finish_cyc;

    for (int n = 0; n < 3000; n++) begin
      begin_cyc;
      flush = ($urandom_range(0, 19) == 0);
      for (int l = 0; l < L; l++)
        if ($urandom % 2) put_iss(l, pick(), pick(), pick(), int'($urandom % 128));
        else put_src(l, pick(), pick());
      for (int k = 0; k < L; k++)
        if ($urandom % 2) begin
          int d = pick();
          put_cmp(k, d, ($urandom % 4 != 0) ? int'(mtag[d]) : int'($urandom % 128), $urandom);
        end
      for (int k = 0; k < L; k++) if ($urandom % 3 == 0) put_ret(k, pick(), $urandom);
      settle;
      finish_cyc;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule